// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block receives command frames over a three-wire serial link: a shift clock pin, a data pin and a frame-end strobe pin. All three pins are sampled in the system clock domain through a short synchronizer. Each rising edge of the shift clock moves a 584-bit register up by one place and takes the data pin into bit 0. The top bit of the register drives the serial output, so a status frame leaves the block while the next command frame arrives.

A frame is 48 twelve-bit channel fields followed by an 8-bit command byte. The highest-numbered channel is sent first, and every field is sent most significant bit first. When the frame-end strobe rises, the block captures the whole register into registered parallel outputs. It decodes the upper nibble of the command byte into one-cycle action pulses. In the same cycle it loads a parallel status word into the register, ready to be shifted out during the next transfer.

The pulses are sync update, async update, correction load and correction toggle. Downstream logic acts on them. The block also keeps a correction-off flag, which the toggle command flips.

Top module: `frame_rx`

## Requirements
- R1: After synchronous reset, the shift register, `chan_data`, `cmd_code`, `ser_dout`, `corr_off` and all four pulse outputs are 0.
- R2: Each rising edge of `ser_clk` shifts the register up by one bit and places `ser_din` in bit 0. `ser_dout` always shows bit 583.
- R3: On a rising edge of `frame_ld`, `cmd_code` takes register bits [7:0], the last eight bits shifted in. Channel k (1..48) is presented at `chan_data[12(k-1) +: 12]` and is taken from register bits [8+12(k-1) +: 12]. So channel 48 arrives first, and each field arrives MSB first.
- R4: The upper nibble of the latched command selects the pulse: 0x1 gives `upd_sync`, 0x2 gives `upd_async`, 0x3 gives `cor_load` and 0x7 gives `cor_tgl`. Every other nibble gives no pulse, and the lower nibble has no effect. A pulse is high for exactly one clock, in the cycle in which `cmd_code` updates. At most one pulse is high at a time.
- R5: `corr_off` starts at 0 and inverts once for every frame whose command nibble is 0x7. No other command changes it.
- R6: On a rising edge of `frame_ld`, the register is loaded with `status_in`. `ser_dout` then shows `status_in[583]`, and the following shift edges present bits 582, 581, and so on down to 0.
- R7: A frame with fewer or more than 584 shift edges is still executed on the rising edge of `frame_ld`, using the register contents exactly as they stand.
- R8: When a `ser_clk` rising edge and a `frame_ld` rising edge are detected in the same clock, the frame is latched from the register as it stood before that cycle. The shift edge is discarded, and the register takes `status_in`.
- R9: `chan_data` and `cmd_code` hold their values, and no pulse occurs, while bits shift without a `frame_ld` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock pin (asynchronous) |
| ser_din | input | 1 | Serial data in |
| frame_ld | input | 1 | Frame-end strobe; a rising edge executes the frame |
| status_in | input | 584 | Status frame loaded into the register at frame end |
| ser_dout | output | 1 | Serial data out (register bit 583) |
| chan_data | output | 576 | Latched channel words, channel k at [12(k-1) +: 12] |
| cmd_code | output | 8 | Latched command byte |
| upd_sync | output | 1 | One-cycle pulse: synchronous update command |
| upd_async | output | 1 | One-cycle pulse: asynchronous update command |
| cor_load | output | 1 | One-cycle pulse: correction load command |
| cor_tgl | output | 1 | One-cycle pulse: correction toggle command |
| corr_off | output | 1 | Correction disable flag |

## Verification
The shift of a data bit and the execution of a frame can fall in the same clock. To provoke this, the bench raises `ser_clk` for the last bit of a frame at the same instant as `frame_ld`. The outcome is judged from the latched outputs. `cmd_code` and `chan_data` must equal the register as it stood before that final edge, which is the first 583 frame bits under one leftover status bit. The expected async pulse must fire, and `ser_dout` must show the new status MSB, proving that the discarded edge did not shift the reloaded register.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam logic [3:0] OPC_UPD_SYNC  = 4'h1;
  localparam logic [3:0] OPC_UPD_ASYNC = 4'h2;
  localparam logic [3:0] OPC_COR_LOAD  = 4'h3;
  localparam logic [3:0] OPC_COR_TGL   = 4'h7;

  typedef struct packed {
    logic upd_sync;
    logic upd_async;
    logic cor_load;
    logic cor_tgl;
  } strb_t;
endpackage

// File: rtl/frx_edge.sv
module frx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (srst) pipe <= '0;
    else      pipe <= {pipe[STAGES-1:0], pin_i};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/frx_shift.sv
module frx_shift #(
  parameter int FRAME_W = 584
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               shift_en,
  input  logic               load_en,
  input  logic               din,
  input  logic [FRAME_W-1:0] load_val,
  output logic [FRAME_W-1:0] sr_o
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (srst)          sr <= '0;
    else if (load_en)  sr <= load_val;
    else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
  end

  assign sr_o = sr;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (srst)
    (shift_en && !load_en) |=> (sr[0] == $past(din)) && (sr[FRAME_W-1] == $past(sr[FRAME_W-2]))); // R2
  AST_LOAD_STS: assert property (@(posedge clk) disable iff (srst)
    (load_en && !shift_en) |=> sr == $past(load_val)); // R6
  AST_COINCIDE: assert property (@(posedge clk) disable iff (srst)
    (load_en && shift_en) |=> sr == $past(load_val)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (srst)
    (!load_en && !shift_en) |=> $stable(sr)); // R9
endmodule

// File: rtl/frx_decode.sv
module frx_decode
  import frx_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd_i,
  output strb_t            strb_o
);
  logic [3:0] nib;
  assign nib = cmd_i[CMD_W-1 -: 4];

  always_comb begin
    strb_o = '0;
    case (nib)
      OPC_UPD_SYNC:  strb_o.upd_sync  = 1'b1;
      OPC_UPD_ASYNC: strb_o.upd_async = 1'b1;
      OPC_COR_LOAD:  strb_o.cor_load  = 1'b1;
      OPC_COR_TGL:   strb_o.cor_tgl   = 1'b1;
      default:       strb_o = '0;
    endcase
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frx_pkg::*;
#(
  parameter int NUM_CH      = 48,
  parameter int CH_W        = 12,
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = NUM_CH * CH_W,
  localparam int FRAME_W    = DATA_W + CMD_W
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic               frame_ld,
  input  logic [FRAME_W-1:0] status_in,
  output logic               ser_dout,
  output logic [DATA_W-1:0]  chan_data,
  output logic [CMD_W-1:0]   cmd_code,
  output logic               upd_sync,
  output logic               upd_async,
  output logic               cor_load,
  output logic               cor_tgl,
  output logic               corr_off
);
  logic sck_rise, ld_rise;
  logic [SYNC_STAGES-1:0] din_pipe;
  logic [FRAME_W-1:0] sr;
  strb_t dec, strb_q;
  logic [DATA_W-1:0] chan_q;
  logic [CMD_W-1:0]  cmd_q;
  logic corr_off_q;

  frx_edge #(.STAGES(SYNC_STAGES)) u_sck (
    .clk(clk), .srst(srst), .pin_i(ser_clk), .rise_o(sck_rise));
  frx_edge #(.STAGES(SYNC_STAGES)) u_ld (
    .clk(clk), .srst(srst), .pin_i(frame_ld), .rise_o(ld_rise));

  // data pin delayed to line up with the shift-clock edge detector
  always_ff @(posedge clk) begin
    if (srst) din_pipe <= '0;
    else      din_pipe <= {din_pipe[SYNC_STAGES-2:0], ser_din};
  end

  frx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .srst(srst), .shift_en(sck_rise), .load_en(ld_rise),
    .din(din_pipe[SYNC_STAGES-1]), .load_val(status_in), .sr_o(sr));

  frx_decode #(.CMD_W(CMD_W)) u_dec (.cmd_i(sr[CMD_W-1:0]), .strb_o(dec));

  always_ff @(posedge clk) begin
    if (srst) begin
      chan_q     <= '0;
      cmd_q      <= '0;
      strb_q     <= '0;
      corr_off_q <= 1'b0;
    end else begin
      strb_q <= '0;
      if (ld_rise) begin
        chan_q <= sr[FRAME_W-1:CMD_W];
        cmd_q  <= sr[CMD_W-1:0];
        strb_q <= dec;
        if (dec.cor_tgl) corr_off_q <= ~corr_off_q;
      end
    end
  end

  assign ser_dout  = sr[FRAME_W-1];
  assign chan_data = chan_q;
  assign cmd_code  = cmd_q;
  assign upd_sync  = strb_q.upd_sync;
  assign upd_async = strb_q.upd_async;
  assign cor_load  = strb_q.cor_load;
  assign cor_tgl   = strb_q.cor_tgl;
  assign corr_off  = corr_off_q;

  logic [3:0] strb_vec;
  assign strb_vec = {upd_sync, upd_async, cor_load, cor_tgl};

  AST_ONE_OP: assert property (@(posedge clk) disable iff (srst)
    $onehot0(strb_vec)); // R4
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (srst)
    (|strb_vec) |=> !(|strb_vec)); // R4
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (srst)
    cor_tgl |-> (corr_off != $past(corr_off))); // R5
  AST_TGL_KEEP: assert property (@(posedge clk) disable iff (srst)
    !cor_tgl |-> $stable(corr_off)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (srst)
    !ld_rise |=> $stable(cmd_code) && $stable(chan_data) && !(|strb_vec)); // R9
endmodule

// File: tb/frame_rx_test.sv
module frame_rx_test;
  localparam int NUM_CH = 48;
  localparam int CH_W   = 12;
  localparam int CMD_W  = 8;
  localparam int DATA_W = NUM_CH * CH_W;
  localparam int FW     = DATA_W + CMD_W;

  localparam int NV = 7;
  localparam logic [7:0]  V_CMD  [NV] = '{8'h10, 8'h2F, 8'h35, 8'h70, 8'h7A, 8'h00, 8'hC3};
  localparam logic [3:0]  V_EXP  [NV] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000};
  localparam logic [11:0] V_SEED [NV] = '{12'h001, 12'hFFF, 12'h5A5, 12'h800, 12'h3C3, 12'h000, 12'h7E1};

  logic clk = 0, srst = 1, ser_clk = 0, ser_din = 0, frame_ld = 0;
  logic [FW-1:0] status_in = '0;
  logic ser_dout, upd_sync, upd_async, cor_load, cor_tgl, corr_off;
  logic [DATA_W-1:0] chan_data;
  logic [CMD_W-1:0]  cmd_code;

  frame_rx uut (
    .clk(clk), .srst(srst), .ser_clk(ser_clk), .ser_din(ser_din), .frame_ld(frame_ld),
    .status_in(status_in), .ser_dout(ser_dout), .chan_data(chan_data), .cmd_code(cmd_code),
    .upd_sync(upd_sync), .upd_async(upd_async), .cor_load(cor_load), .cor_tgl(cor_tgl),
    .corr_off(corr_off));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int c_sync = 0, c_async = 0, c_load = 0, c_tgl = 0;
  logic [FW-1:0] rx;
  logic [FW-1:0] prev_sts;
  logic exp_off;

  always @(posedge clk) begin
    if (upd_sync)  c_sync++;
    if (upd_async) c_async++;
    if (cor_load)  c_load++;
    if (cor_tgl)   c_tgl++;
  end

  task automatic chk(input string req, input logic [599:0] act, input logic [599:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    c_sync = 0; c_async = 0; c_load = 0; c_tgl = 0;
  endtask

  // shift b[n-1] first down to b[0]; optionally raise frame_ld with the last edge
  task automatic shift_bits(input logic [599:0] b, input int n, input bit ld_with_last);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = b[i];
      ser_clk = 0;
      wait_clk(4);
      if (i < FW) rx[i] = ser_dout;
      if (i == 0 && ld_with_last) frame_ld = 1;
      ser_clk = 1;
      wait_clk(4);
    end
    ser_clk = 0;
    wait_clk(4);
    if (ld_with_last) begin
      frame_ld = 0;
      wait_clk(6);
    end
  endtask

  task automatic pulse_ld();
    frame_ld = 1;
    wait_clk(4);
    frame_ld = 0;
    wait_clk(6);
  endtask

  function automatic logic [FW-1:0] sts(input int t);
    logic [7:0] p;
    p = 8'(t * 29) ^ 8'hA5;
    return {73{p}};
  endfunction

  function automatic logic [FW-1:0] mk_frame(input logic [11:0] seed, input logic [7:0] cmd);
    logic [FW-1:0] f;
    for (int k = 1; k <= NUM_CH; k++)
      f[CMD_W + (k-1)*CH_W +: CH_W] = (seed + 12'(k * 149)) ^ 12'(k << 4);
    f[CMD_W-1:0] = cmd;
    return f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [FW-1:0] f, reg_exp;
    logic [599:0] b;
    wait_clk(5);
    srst = 0;
    wait_clk(3);
    // R1 reset state
    chk("R1 cmd", 600'(cmd_code), 600'h0);
    chk("R1 chan", 600'(chan_data), 600'h0);
    chk("R1 dout", 600'(ser_dout), 600'h0);
    chk("R1 corr_off", 600'(corr_off), 600'h0);
    chk("R1 pulses", 600'({upd_sync, upd_async, cor_load, cor_tgl}), 600'h0);
    prev_sts = '0;
    exp_off = 0;

    // vector table: full frames, R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      f = mk_frame(V_SEED[v], V_CMD[v]);
      status_in = sts(v);
      clr_cnt();
      shift_bits(600'(f), FW, 0);
      chk("R6 status shifted out", 600'(rx), 600'(prev_sts));
      chk("R2 dout is last first-sent bit", 600'(ser_dout), 600'(f[FW-1]));
      pulse_ld();
      chk("R3 channels", 600'(chan_data), 600'(f[FW-1:CMD_W]));
      chk("R3 command", 600'(cmd_code), 600'(V_CMD[v]));
      chk("R4 pulses", 600'({c_sync[3:0], c_async[3:0], c_load[3:0], c_tgl[3:0]}),
          600'({3'b0, V_EXP[v][3], 3'b0, V_EXP[v][2], 3'b0, V_EXP[v][1], 3'b0, V_EXP[v][0]}));
      if (V_EXP[v][0]) exp_off = ~exp_off;
      chk("R5 corr_off", 600'(corr_off), 600'(exp_off));
      chk("R6 status msb", 600'(ser_dout), 600'(status_in[FW-1]));
      prev_sts = status_in;
    end

    // R9: shifting alone changes no output; then R7 short frame of 100 bits
    b = '0;
    b[99:0] = {23'h5A5A5A, 69'h1_2345_6789_ABCD_EF01, 8'h35};
    clr_cnt();
    f = mk_frame(V_SEED[NV-1], V_CMD[NV-1]);
    shift_bits(b, 100, 0);
    chk("R9 cmd held", 600'(cmd_code), 600'(V_CMD[NV-1]));
    chk("R9 chan held", 600'(chan_data), 600'(f[FW-1:CMD_W]));
    chk("R9 no pulse", 600'(c_sync + c_async + c_load + c_tgl), 600'h0);
    reg_exp = {prev_sts[FW-101:0], b[99:0]};
    status_in = sts(20);
    pulse_ld();
    chk("R7 short frame cmd", 600'(cmd_code), 600'(reg_exp[7:0]));
    chk("R7 short frame chan", 600'(chan_data), 600'(reg_exp[FW-1:CMD_W]));
    chk("R7 short frame pulse", 600'(c_load), 600'h1);
    prev_sts = status_in;

    // R7 long frame of 596 bits: only the last 584 remain
    b = {75{8'h9C}};
    b[7:0] = 8'h12;
    b[595:584] = 12'hFFF;
    clr_cnt();
    shift_bits(b, 596, 0);
    status_in = sts(21);
    pulse_ld();
    chk("R7 long frame cmd", 600'(cmd_code), 600'h12);
    chk("R7 long frame chan", 600'(chan_data), 600'(b[FW-1:CMD_W]));
    chk("R7 long frame pulse", 600'(c_sync), 600'h1);
    prev_sts = status_in;

    // R8: last shift edge coincides with frame end
    f = mk_frame(12'h4B1, 8'h00);
    f[8:1] = 8'h21;
    f[0] = 1'b1;
    reg_exp = {prev_sts[0], f[FW-1:1]};
    status_in = sts(22);
    clr_cnt();
    shift_bits(600'(f), FW, 1);
    chk("R8 cmd from pre-edge register", 600'(cmd_code), 600'(reg_exp[7:0]));
    chk("R8 chan from pre-edge register", 600'(chan_data), 600'(reg_exp[FW-1:CMD_W]));
    chk("R8 async pulse", 600'(c_async), 600'h1);
    chk("R8 edge discarded, status msb", 600'(ser_dout), 600'(status_in[FW-1]));
    shift_bits(600'h1, 1, 0);
    chk("R8 next bit is status 582", 600'(ser_dout), 600'(status_in[FW-2]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule